// File: doc/BRIEF.md
# Mode Latch with Per-Mode Clock Counters

This block tracks which of four operating modes a front-end chip would be in and counts the clock edges that arrive in each mode. The 2-bit mode lines from the cable are captured by a latch that follows them while the change-mode gate is low and freezes them while the gate is high. The host can override the latched mode through a 16-bit control word. The block also outputs the decoded active mode, the clock that drives the counters and the four counter values. Everything runs on one system clock. The external clock and the mode lines are assumed to be synchronised to that clock already, and edges of the selected clock are found by comparing it with its value in the previous cycle.

The control word mixes static bits with pulse bits. A pulse bit acts during the write and always reads back zero. A set/reset pair of bits chooses between the external clock and a software clock. The software clock flips once for each host write that carries the toggle bit, so the host can step the counters one edge at a time. The clock source is a two-state machine. In SRC_EXT, a write with bit 7 set and bit 8 clear takes the transition to SRC_INT. In SRC_INT, a write with bit 8 set and bit 7 clear takes the transition back to SRC_EXT. Any other write leaves the state where it is.

A master-reset pulse clears the block to its power-up state. The block also sends a one-cycle pulse to neighbouring logic, which owns the chip-count register, the boundary counter and the FIFOs.

Top module: `mode_clk_ctrl`

## Requirements
- R1: The mode latch loads `mode_lines` on every clock edge at which `chg_mode` is 0, and holds its value on every edge at which `chg_mode` is 1. The latched value appears on `ctrl_rd[4:3]` one cycle after the edge that loads it, so a new mode takes effect once the gate falls.
- R2: A control write with bit 2 set makes `active_mode` equal to write bits 1:0 from the next cycle on. A later write with bit 2 clear returns `active_mode` to the latched mode. The mode encoding is 0 for initialise, 1 for acquire, 2 for digitise and 3 for readout.
- R3: `ctrl_rd` returns the following fields:
  - bits 2:0 hold the last written force bit and forced mode;
  - bits 4:3 hold the latched mode;
  - bits 6:5 show the live `mode_lines`;
  - bit 7 is 1 while the software clock is selected.
- R4: Control bits 8:7 select the clock source. 10 selects external and 01 selects the software clock. Both 00 and 11 leave the selection unchanged. After reset the external clock is selected.
- R5: When the software clock is selected, each write with bit 9 set inverts `sel_clk`, and writes without bit 9 leave it unchanged. While the software clock is selected, `ext_clk` has no effect on `sel_clk`. While the external clock is selected, `sel_clk` follows `ext_clk` and bit 9 has no effect.
- R6: The initialise counter is 12 bits wide, and the acquire and digitise counters are 8 bits wide. Each one counts rising edges of `sel_clk` only while `active_mode` equals its own mode.
- R7: The 8-bit readout counter counts both rising and falling edges of `sel_clk` while `active_mode` is 3.
- R8: Writing 1 to bits 10, 11, 12 or 13 clears the initialise, acquire, digitise or readout counter respectively. When read, bits 13:10 show the active mode one-hot, with bit 10 standing for initialise. Bits 15:14 and 9:8 always read 0.
- R9: A write with bit 15 set has the following effects:
  - all four counters go to zero;
  - the force bit, forced mode and clock source clear;
  - the mode latch returns to initialise;
  - the rest of that write is ignored;
  - `mreset_o` goes high for exactly the next cycle.
- R10: While `cnt_wr_en` is high, the counter chosen by `cnt_wr_sel` (using the mode encoding) loads the low bits of `cnt_wr_data`.
- R11: A counter at its all-ones value stays at all-ones on further edges instead of wrapping to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_lines | input | 2 | External mode lines |
| chg_mode | input | 1 | Change-mode gate; latch holds while high |
| ext_clk | input | 1 | External pipeline clock, synchronised level |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_sel | input | 2 | Counter chosen for loading (mode encoding) |
| cnt_wr_data | input | 12 | Counter load value |
| ctrl_rd | output | 16 | Control word readback |
| active_mode | output | 2 | Active operating mode |
| mode_dec | output | 4 | Active mode, one-hot |
| sel_clk | output | 1 | Selected clock level |
| cnt_init | output | 12 | Initialise-mode edge count |
| cnt_acq | output | 8 | Acquire-mode edge count |
| cnt_dig | output | 8 | Digitise-mode edge count |
| cnt_rdo | output | 8 | Readout-mode edge count |
| mreset_o | output | 1 | One-cycle master reset pulse to neighbours |

## Verification
The hardest state to reach from the ports is a counter sitting at its ceiling. Driving the 12-bit counter there with clock pulses alone would take thousands of edges, so the bench loads values just below all-ones and then applies two more edges to show the counter holds. The software clock path is also awkward, because each edge needs a full host write followed by a cycle for edge detection. The bench therefore steps it one write at a time, mixing in writes that carry the 11 and 00 select codes. It also toggles `ext_clk` while the software clock is selected, to show that the external clock has no effect then.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
    typedef enum logic [1:0] {
        MD_INIT = 2'd0,
        MD_ACQ  = 2'd1,
        MD_DIG  = 2'd2,
        MD_RDO  = 2'd3
    } mode_e;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } src_e;

    localparam int CTL_W     = 16;
    localparam int B_FORCE   = 2;
    localparam int B_SEL_INT = 7;
    localparam int B_SEL_EXT = 8;
    localparam int B_TOGGLE  = 9;
    localparam int B_CLR0    = 10;
    localparam int B_MRST    = 15;
endpackage

// File: rtl/mode_gate_latch.sv
module mode_gate_latch
    import mclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mrst,
    input  logic [1:0] mode_lines,
    input  logic       chg_mode,
    output mode_e      held
);
    // Follows the lines while the gate is low, freezes while it is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= MD_INIT;
        end else if (mrst) begin
            held <= MD_INIT;
        end else if (!chg_mode) begin
            held <= mode_e'(mode_lines);
        end
    end
endmodule

// File: rtl/clk_source_sel.sv
module clk_source_sel
    import mclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mrst,
    input  logic wr,
    input  logic set_int,
    input  logic set_ext,
    input  logic toggle,
    input  logic ext_clk,
    output src_e src,
    output logic sel_clk,
    output logic rise,
    output logic fall
);
    src_e src_next;
    logic sw_clk;
    logic sel_prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= SRC_EXT;
        end else if (mrst) begin
            src <= SRC_EXT;
        end else begin
            src <= src_next;
        end
    end

    // Transitions: only a clean 01 or 10 pair moves the state.
    always_comb begin
        src_next = src;
        unique case (src)
            SRC_EXT: if (wr && set_int && !set_ext) src_next = SRC_INT;
            SRC_INT: if (wr && set_ext && !set_int) src_next = SRC_EXT;
        endcase
    end

    // Outputs: software clock level, selected clock and its edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_clk   <= 1'b0;
            sel_prev <= 1'b0;
        end else begin
            sel_prev <= sel_clk;
            if (mrst) begin
                sw_clk <= 1'b0;
            end else if (wr && toggle && src == SRC_INT) begin
                sw_clk <= ~sw_clk;
            end
        end
    end

    assign sel_clk = (src == SRC_INT) ? sw_clk : ext_clk;
    assign rise    = sel_clk & ~sel_prev;
    assign fall    = ~sel_clk & sel_prev;
endmodule

// File: rtl/edge_counter.sv
module edge_counter #(
    parameter int W    = 8,
    parameter bit BOTH = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         en,
    input  logic         rise,
    input  logic         fall,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic step;
    assign step = en && (rise || (BOTH && fall));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (step && q != MAXV) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/mode_clk_ctrl.sv
module mode_clk_ctrl
    import mclk_pkg::*;
#(
    parameter int INIT_W = 12,
    parameter int MODE_W = 8,
    localparam int CW    = (INIT_W > MODE_W) ? INIT_W : MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_lines,
    input  logic              chg_mode,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic              cnt_wr_en,
    input  logic [1:0]        cnt_wr_sel,
    input  logic [CW-1:0]     cnt_wr_data,
    output logic [CTL_W-1:0]  ctrl_rd,
    output logic [1:0]        active_mode,
    output logic [3:0]        mode_dec,
    output logic              sel_clk,
    output logic [INIT_W-1:0] cnt_init,
    output logic [MODE_W-1:0] cnt_acq,
    output logic [MODE_W-1:0] cnt_dig,
    output logic [MODE_W-1:0] cnt_rdo,
    output logic              mreset_o
);
    localparam int NMODE = 4;

    logic  mrst;
    logic  wr;
    logic  force_q;
    logic  [1:0] fmode_q;
    mode_e latched;
    mode_e active;
    src_e  src;
    logic  rise;
    logic  fall;
    logic  unused_wr_bits;

    assign mrst = wr_en && wr_data[B_MRST];
    assign wr   = wr_en && !wr_data[B_MRST];
    assign unused_wr_bits = ^{wr_data[14], wr_data[6:3]};

    mode_gate_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrst       (mrst),
        .mode_lines (mode_lines),
        .chg_mode   (chg_mode),
        .held       (latched)
    );

    clk_source_sel u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrst    (mrst),
        .wr      (wr),
        .set_int (wr_data[B_SEL_INT]),
        .set_ext (wr_data[B_SEL_EXT]),
        .toggle  (wr_data[B_TOGGLE]),
        .ext_clk (ext_clk),
        .src     (src),
        .sel_clk (sel_clk),
        .rise    (rise),
        .fall    (fall)
    );

    // Static control bits: force mode and forced value, rewritten on every write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_q  <= 1'b0;
            fmode_q  <= 2'd0;
            mreset_o <= 1'b0;
        end else begin
            mreset_o <= mrst;
            if (mrst) begin
                force_q <= 1'b0;
                fmode_q <= 2'd0;
            end else if (wr) begin
                force_q <= wr_data[B_FORCE];
                fmode_q <= wr_data[1:0];
            end
        end
    end

    assign active      = force_q ? mode_e'(fmode_q) : latched;
    assign active_mode = active;
    assign mode_dec    = 4'b0001 << active;

    assign ctrl_rd = {2'b00, mode_dec, 2'b00, (src == SRC_INT),
                      mode_lines, latched, force_q, fmode_q};

    for (genvar g = 0; g < NMODE; g++) begin : g_cnt
        localparam int W    = (g == 0) ? INIT_W : MODE_W;
        localparam bit BOTH = (g == NMODE - 1);
        logic [W-1:0] q;

        edge_counter #(.W(W), .BOTH(BOTH)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (mrst || (wr && wr_data[B_CLR0 + g])),
            .ld     (cnt_wr_en && cnt_wr_sel == 2'(g)),
            .ld_val (cnt_wr_data[W-1:0]),
            .en     (active == mode_e'(g)),
            .rise   (rise),
            .fall   (fall),
            .q      (q)
        );

        if (g == 0) begin : g_o0
            assign cnt_init = q;
        end else if (g == 1) begin : g_o1
            assign cnt_acq = q;
        end else if (g == 2) begin : g_o2
            assign cnt_dig = q;
        end else begin : g_o3
            assign cnt_rdo = q;
        end
    end
endmodule

// File: rtl/mclk_chk.sv
module mclk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chg_mode,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        cnt_wr_en,
    input logic [1:0]  cnt_wr_sel,
    input logic [15:0] ctrl_rd,
    input logic [1:0]  active_mode,
    input logic [3:0]  mode_dec,
    input logic        sel_clk,
    input logic [7:0]  cnt_acq,
    input logic [7:0]  cnt_rdo,
    input logic        mreset_o
);
    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_mode && !(wr_en && wr_data[15])) |=> ctrl_rd[4:3] == $past(ctrl_rd[4:3]));

    // R8
    onehot_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_dec) == 1 && ctrl_rd[13:10] == mode_dec);

    // R8
    pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[15:14] == 2'b00 && ctrl_rd[9:8] == 2'b00);

    // R5
    soft_clk_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[7] && !(wr_en && (wr_data[9] || wr_data[8] || wr_data[15])))
        |=> $stable(sel_clk));

    // R6
    acq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode != 2'd1 && !(wr_en && (wr_data[11] || wr_data[15]))
         && !(cnt_wr_en && cnt_wr_sel == 2'd1)) |=> $stable(cnt_acq));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rdo == '1 && !(wr_en && (wr_data[13] || wr_data[15]))
         && !(cnt_wr_en && cnt_wr_sel == 2'd3)) |=> cnt_rdo == '1);

    // R9
    mreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15]) |=> (mreset_o && cnt_acq == 8'd0 && cnt_rdo == 8'd0));
endmodule

bind mode_clk_ctrl mclk_chk u_mclk_chk (.*);

// File: tb/test_mode_clk_ctrl.sv
`timescale 1ns/1ps
module test_mode_clk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_lines = 2'd0;
    logic        chg_mode = 1'b0;
    logic        ext_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        cnt_wr_en = 1'b0;
    logic [1:0]  cnt_wr_sel = 2'd0;
    logic [11:0] cnt_wr_data = 12'h0;
    logic [15:0] ctrl_rd;
    logic [1:0]  active_mode;
    logic [3:0]  mode_dec;
    logic        sel_clk;
    logic [11:0] cnt_init;
    logic [7:0]  cnt_acq, cnt_dig, cnt_rdo;
    logic        mreset_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mode_clk_ctrl i_mode_clk_ctrl (.*);

    // {chg_mode, mode_lines, expected latched mode}
    localparam logic [4:0] VEC [8] = '{
        5'b0_01_01, 5'b0_10_10, 5'b1_11_10, 5'b1_00_10,
        5'b0_00_00, 5'b0_11_11, 5'b1_01_11, 5'b0_01_01
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic pulse();
        ext_clk = 1'b1; tick();
        ext_clk = 1'b0; tick();
    endtask

    task automatic load(input logic [1:0] sel, input logic [11:0] v);
        cnt_wr_en = 1'b1; cnt_wr_sel = sel; cnt_wr_data = v;
        tick();
        cnt_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R3 R8 reset state: init decoded, external source
        chk("R3 reset ctrl_rd", ctrl_rd, 16'h0400);
        chk("R6 reset cnt_init", 16'(cnt_init), 16'h0);
        chk("R7 reset cnt_rdo", 16'(cnt_rdo), 16'h0);
        chk("R9 reset mreset_o", 16'(mreset_o), 16'h0);

        // R1 mode latch table
        for (int i = 0; i < 8; i++) begin
            chg_mode = VEC[i][4];
            mode_lines = VEC[i][3:2];
            tick();
            chk("R1 latched mode", 16'(ctrl_rd[4:3]), 16'(VEC[i][1:0]));
            chk("R1 active mode", 16'(active_mode), 16'(VEC[i][1:0]));
            chk("R3 live lines", 16'(ctrl_rd[6:5]), 16'(VEC[i][3:2]));
        end
        chg_mode = 1'b0;

        // R6 initialise counter, rising edges only
        mode_lines = 2'd0; tick();
        repeat (3) pulse();
        chk("R6 cnt_init", 16'(cnt_init), 16'd3);
        chk("R6 cnt_acq idle", 16'(cnt_acq), 16'd0);
        chk("R7 cnt_rdo idle", 16'(cnt_rdo), 16'd0);

        // R7 readout counter, both edges
        mode_lines = 2'd3; tick();
        repeat (3) pulse();
        chk("R7 cnt_rdo both edges", 16'(cnt_rdo), 16'd6);
        chk("R6 cnt_init other mode", 16'(cnt_init), 16'd3);

        // R2 force to acquire
        wr(16'h0005);
        chk("R2 forced active", 16'(active_mode), 16'd1);
        chk("R3 static bits", 16'(ctrl_rd[2:0]), 16'd5);
        chk("R8 one-hot readback", 16'(ctrl_rd[13:10]), 16'b0010);
        repeat (2) pulse();
        chk("R6 cnt_acq", 16'(cnt_acq), 16'd2);
        chk("R7 cnt_rdo while forced away", 16'(cnt_rdo), 16'd6);
        wr(16'h0000);
        chk("R2 override released", 16'(active_mode), 16'd3);

        // R8 clear readout counter only
        wr(16'h2000);
        chk("R8 cnt_rdo cleared", 16'(cnt_rdo), 16'd0);
        chk("R8 cnt_acq kept", 16'(cnt_acq), 16'd2);
        chk("R8 pulse bits read 0", ctrl_rd & 16'hC300, 16'h0000);

        // R4 R5 software clock
        wr(16'h0080);
        chk("R4 internal selected", 16'(ctrl_rd[7]), 16'd1);
        ext_clk = 1'b1; tick();
        chk("R5 ext ignored", 16'(sel_clk), 16'd0);
        ext_clk = 1'b0; tick();
        chk("R5 no count from ext", 16'(cnt_rdo), 16'd0);
        wr(16'h0200);
        chk("R5 toggle high", 16'(sel_clk), 16'd1);
        tick();
        chk("R7 soft rise counted", 16'(cnt_rdo), 16'd1);
        wr(16'h0000); tick();
        chk("R5 no toggle without bit 9", 16'(sel_clk), 16'd1);
        wr(16'h0180);
        chk("R4 code 11 keeps internal", 16'(ctrl_rd[7]), 16'd1);
        wr(16'h0200); tick();
        chk("R5 toggle low", 16'(sel_clk), 16'd0);
        chk("R7 soft fall counted", 16'(cnt_rdo), 16'd2);
        wr(16'h0100);
        chk("R4 external selected", 16'(ctrl_rd[7]), 16'd0);
        ext_clk = 1'b1; #0.5;
        chk("R5 sel follows ext", 16'(sel_clk), 16'd1);
        tick(); ext_clk = 1'b0; tick();
        chk("R7 ext edges counted", 16'(cnt_rdo), 16'd4);
        wr(16'h0200); tick();
        chk("R5 toggle ignored on ext", 16'(sel_clk), 16'd0);
        chk("R5 no stray count", 16'(cnt_rdo), 16'd4);

        // R10 R11 load and saturation
        load(2'd1, 12'h0FE);
        chk("R10 cnt_acq loaded", 16'(cnt_acq), 16'h00FE);
        wr(16'h0005);
        pulse();
        chk("R11 cnt_acq at max", 16'(cnt_acq), 16'h00FF);
        pulse();
        chk("R11 cnt_acq saturates", 16'(cnt_acq), 16'h00FF);
        load(2'd0, 12'hFFE);
        chk("R10 cnt_init loaded", 16'(cnt_init), 16'h0FFE);
        wr(16'h0004);
        repeat (2) pulse();
        chk("R11 cnt_init saturates", 16'(cnt_init), 16'h0FFF);
        wr(16'h0000);
        load(2'd3, 12'h0FF);
        pulse();
        chk("R11 cnt_rdo saturates", 16'(cnt_rdo), 16'h00FF);

        // R9 master reset
        wr(16'h0085 | 16'h8000);
        chk("R9 mreset_o pulse", 16'(mreset_o), 16'd1);
        chk("R9 counters zero", 16'(cnt_init) | 16'(cnt_acq) | 16'(cnt_dig) | 16'(cnt_rdo), 16'd0);
        chk("R9 static bits cleared", 16'(ctrl_rd[2:0]), 16'd0);
        chk("R9 source back to external", 16'(ctrl_rd[7]), 16'd0);
        tick();
        chk("R9 mreset_o one cycle", 16'(mreset_o), 16'd0);
        chk("R1 latch reloads after reset", 16'(active_mode), 16'd3);

        finish_run();
    end
endmodule